// File: doc/BRIEF.md
# Dual-Section Decade Counter

This block is a decade counter made of two stages that count independently. One stage divides by two and the other divides by five. Each stage has its own step input. A step input acts like a clock that fires on its falling edge. Both step inputs are sampled by one system clock, so every flop in the block sits in the same clock domain and no logic is clocked by data.

A mode input, latched during reset, chooses how the two stages are chained.

- In decimal mode, the divide-by-two stage takes the `divTwoIn` edges. When that stage falls from 1 to 0, it steps the divide-by-five stage in the same system cycle. The 4-bit output then reads as a binary-coded decimal digit from 0 to 9.
- In split mode, the divide-by-five stage takes the `divFiveIn` edges. When it wraps from 4 to 0, it toggles the divide-by-two stage in the same cycle. Bit 0 then becomes a square wave with a 50% duty cycle at one tenth of the input edge rate.

An active-high asynchronous reset clears the whole count.

Top module: `decade_counter`

## Requirements
- R1: While `rst` is high, `count` is 0. This holds as soon as `rst` rises, without waiting for a `clk` edge.
- R2: A falling edge on a step input is seen by the `clk` edge that first samples the input low, provided the previous sample was high. The count changes at the next `clk` edge after that one.
- R3: The divide-by-five stage, `count[3:1]`, steps 0,1,2,3,4 and then back to 0. It never holds a value above 4.
- R4: In decimal mode (mode 0), each `divTwoIn` fall adds 1 to `count` read as a binary value, and 9 wraps to 0. `count[0]` is the least significant bit.
- R5: In decimal mode, falls on `divFiveIn` leave `count` unchanged.
- R6: In split mode (mode 1), each `divFiveIn` fall steps `count[3:1]`. The step that takes it from 4 to 0 also toggles `count[0]` on the same `clk` edge.
- R7: In split mode, falls on `divTwoIn` leave `count` unchanged.
- R8: In split mode, starting from reset, `count[0]` is high for exactly 5 of every 10 `divFiveIn` falls. It is high after falls 5 to 9 and low after falls 10 to 14.
- R9: After reset is released, a step input counts only once it has been sampled high after reset. An input that is low at release, or falls on the release cycle, does not count until it has gone high and then low again.
- R10: `modeSel` is captured on `clk` edges while `rst` is high. Changing it while counting has no effect on how the count advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the step inputs |
| rst | input | 1 | Asynchronous active-high reset |
| divTwoIn | input | 1 | Step input of the divide-by-two stage (falling edge) |
| divFiveIn | input | 1 | Step input of the divide-by-five stage (falling edge) |
| modeSel | input | 1 | 0 = decimal chaining, 1 = split chaining; latched in reset |
| count | output | 4 | Bit 0 = divide-by-two stage, bits 3:1 = divide-by-five stage |

## Verification
The bench aims at the chaining boundaries.

- It checks the 9-to-0 wrap in decimal mode. A design whose carry fired one cycle late, or on the wrong polarity of bit 0, would pass through 10 or 11, or skip a decade.
- In split mode it tracks bit 0 across twenty falls. A toggle placed at the wrong divide-by-five value would show up as an uneven duty cycle.
- It drives the step input that the active mode should ignore, and it changes the mode pin while counting. A design that counted those inputs, or that followed the live mode pin, would drift from the reference.
- It holds a step input low across reset release, and it drops one exactly at release. A design that cleared its samplers to 1 would count a phantom edge.

// File: rtl/decade_pkg.sv
package decade_pkg;
  // Step strobes from control to datapath, one cycle wide each.
  typedef struct packed {
    logic stepLow;   // toggle the divide-by-two stage
    logic stepHigh;  // advance the divide-by-N stage
  } stepStrobe_t;
endpackage

// File: rtl/decade_ctrl.sv
module decade_ctrl
  import decade_pkg::*;
#(
  parameter int HI_MOD = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        divTwoIn,
  input  logic        divFiveIn,
  input  logic        modeSel,
  input  logic        loNow,
  input  logic        hiAtTop,
  output stepStrobe_t strobe,
  output logic        modeBiq
);
  localparam int N_IN = 2;

  logic [N_IN-1:0] rawIn;
  logic [N_IN-1:0] sampNow;
  logic [N_IN-1:0] sampPrev;
  logic [N_IN-1:0] fallSeen;

  assign rawIn = {divFiveIn, divTwoIn};

  // Samplers clear to 0, so an input must be seen high after reset
  // before any of its falls can count.
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      sampNow  <= '0;
      sampPrev <= '0;
    end else begin
      sampNow  <= rawIn;
      sampPrev <= sampNow;
    end
  end

  for (genvar i = 0; i < N_IN; i++) begin : g_fall
    assign fallSeen[i] = sampPrev[i] & ~sampNow[i];
  end

  // The mode is captured only while reset is held.
  always_ff @(posedge clk) begin
    if (rst) modeBiq <= modeSel;
  end

  always_comb begin
    if (modeBiq) begin
      strobe.stepHigh = fallSeen[1];
      strobe.stepLow  = fallSeen[1] & hiAtTop;
    end else begin
      strobe.stepLow  = fallSeen[0];
      strobe.stepHigh = fallSeen[0] & loNow;
    end
  end
endmodule

// File: rtl/decade_dp.sv
module decade_dp
  import decade_pkg::*;
#(
  parameter int HI_MOD = 5,
  localparam int HI_W  = $clog2(HI_MOD)
) (
  input  logic            clk,
  input  logic            rst,
  input  stepStrobe_t     strobe,
  output logic            loQ,
  output logic [HI_W-1:0] hiQ,
  output logic            hiAtTop
);
  localparam logic [HI_W-1:0] HI_TOP = HI_W'(HI_MOD - 1);

  assign hiAtTop = (hiQ == HI_TOP);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      loQ <= 1'b0;
      hiQ <= '0;
    end else begin
      if (strobe.stepLow)  loQ <= ~loQ;
      if (strobe.stepHigh) hiQ <= hiAtTop ? '0 : HI_W'(hiQ + 1'b1);
    end
  end
endmodule

// File: rtl/decade_counter.sv
module decade_counter
  import decade_pkg::*;
#(
  parameter int HI_MOD = 5,
  localparam int HI_W  = $clog2(HI_MOD)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          divTwoIn,
  input  logic          divFiveIn,
  input  logic          modeSel,
  output logic [HI_W:0] count
);
  stepStrobe_t     strobe;
  logic            loQ;
  logic [HI_W-1:0] hiQ;
  logic            hiAtTop;
  logic            modeBiq;

  decade_ctrl #(.HI_MOD(HI_MOD)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .divTwoIn (divTwoIn),
    .divFiveIn(divFiveIn),
    .modeSel  (modeSel),
    .loNow    (loQ),
    .hiAtTop  (hiAtTop),
    .strobe   (strobe),
    .modeBiq  (modeBiq)
  );

  decade_dp #(.HI_MOD(HI_MOD)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .loQ    (loQ),
    .hiQ    (hiQ),
    .hiAtTop(hiAtTop)
  );

  assign count = {hiQ, loQ};
endmodule

// File: rtl/decade_checker.sv
module decade_checker #(
  parameter int HI_MOD = 5,
  localparam int HI_W  = $clog2(HI_MOD)
) (
  input logic          clk,
  input logic          rst,
  input logic          modeLatched,
  input logic [HI_W:0] count
);
  int valNow;
  assign valNow = int'(count[0]) + 2 * int'(count[HI_W:1]);

  p_reset_clear_r1: assert property (@(posedge clk) rst |-> count == '0)
    else $error("R1 count not clear in reset");

  p_high_range_r3: assert property (@(posedge clk) disable iff (rst)
    int'(count[HI_W:1]) < HI_MOD)
    else $error("R3 high stage out of range");

  p_decimal_step_r4: assert property (@(posedge clk) disable iff (rst)
    (!modeLatched && valNow != $past(valNow)) |->
      valNow == (($past(valNow) == 2*HI_MOD-1) ? 0 : $past(valNow) + 1))
    else $error("R4 decimal step wrong");

  p_split_toggle_r6: assert property (@(posedge clk) disable iff (rst)
    (modeLatched && count[0] != $past(count[0])) |->
      (int'($past(count[HI_W:1])) == HI_MOD-1 && count[HI_W:1] == '0))
    else $error("R6 low toggle outside wrap");

  p_mode_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(modeLatched))
    else $error("R10 mode moved while counting");
endmodule

bind decade_counter decade_checker #(.HI_MOD(HI_MOD)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .modeLatched(modeBiq),
  .count      (count)
);

// File: tb/sim_decade_counter.sv
module sim_decade_counter;
  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic rst = 1'b1, divTwoIn = 1'b1, divFiveIn = 1'b1, modeSel = 1'b0;
  logic [3:0] count;

  decade_counter u0 (
    .clk(clk), .rst(rst), .divTwoIn(divTwoIn), .divFiveIn(divFiveIn),
    .modeSel(modeSel), .count(count)
  );

  int total = 0, bad = 0;
  string curReq = "R1";
  bit done = 0;

  // Behavioural reference model
  int mLo = 0, mHi = 0;
  bit mMode = 0;
  bit a1 = 0, a2 = 0, b1 = 0, b2 = 0;
  logic [3:0] expect_q;
  assign expect_q = {mHi[2:0], mLo[0]};

  always @(posedge clk) begin
    if (rst) begin
      mLo = 0; mHi = 0; mMode = modeSel;
      a1 = 0; a2 = 0; b1 = 0; b2 = 0;
    end else begin
      bit fa, fb;
      fa = a2 && !a1;
      fb = b2 && !b1;
      if (!mMode && fa) begin
        if (mLo == 1) begin mLo = 0; mHi = (mHi + 1) % 5; end
        else mLo = 1;
      end
      if (mMode && fb) begin
        if (mHi == 4) begin mHi = 0; mLo = 1 - mLo; end
        else mHi = mHi + 1;
      end
      a2 = a1; a1 = divTwoIn;
      b2 = b1; b1 = divFiveIn;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk)
    if (!done) chk(count === expect_q, curReq, count, expect_q);

  task automatic doReset(bit mode);
    @(negedge clk); #1 rst = 1'b1; modeSel = mode;
    repeat (3) @(negedge clk);
    chk(count == 4'd0, "R1", count, 0);
    #1 rst = 1'b0;
  endtask

  task automatic pulseA();
    @(negedge clk); #1 divTwoIn = 1'b0;
    repeat (2) @(negedge clk); #1 divTwoIn = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulseB();
    @(negedge clk); #1 divFiveIn = 1'b0;
    repeat (2) @(negedge clk); #1 divFiveIn = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state
    curReq = "R1";
    doReset(1'b0);
    repeat (2) @(negedge clk);

    // R2 latency of one fall
    curReq = "R2";
    @(negedge clk); #1 divTwoIn = 1'b0;
    @(negedge clk); chk(count == 4'd0, "R2", count, 0);
    @(negedge clk); chk(count == 4'd1, "R2", count, 1);
    #1 divTwoIn = 1'b1;
    repeat (2) @(negedge clk);

    // R4 decimal counting through the wrap
    curReq = "R4";
    for (int i = 2; i <= 12; i++) begin
      pulseA();
      chk(count == 4'(i % 10), "R4", count, i % 10);
    end

    // R5 other input ignored in decimal mode
    curReq = "R5";
    for (int i = 0; i < 3; i++) pulseB();
    chk(count == 4'd2, "R5", count, 2);

    // R10 mode pin moved while counting
    curReq = "R10";
    @(negedge clk); #1 modeSel = 1'b1;
    pulseB();
    chk(count == 4'd2, "R10", count, 2);
    pulseA();
    chk(count == 4'd3, "R10", count, 3);

    // R1 async clear mid-cycle
    curReq = "R1";
    @(negedge clk); #1 rst = 1'b1;
    #1 chk(count == 4'd0, "R1", count, 0);
    repeat (2) @(negedge clk);
    #1 rst = 1'b0;

    // Split mode: R3, R6, R8
    curReq = "R6";
    doReset(1'b1);
    begin
      int highs = 0;
      for (int n = 1; n <= 20; n++) begin
        pulseB();
        chk(count[3:1] == 3'(n % 5), "R3", count[3:1], n % 5);
        chk(count[0] == 1'((n / 5) % 2), "R6", count[0], (n / 5) % 2);
        if (n >= 5 && n <= 14 && count[0]) highs++;
      end
      chk(highs == 5, "R8", highs, 5);
    end

    // R7 other input ignored in split mode
    curReq = "R7";
    for (int i = 0; i < 3; i++) pulseA();
    chk(count == 4'd0, "R7", count, 0);
    pulseB();
    chk(count == 4'd2, "R7", count, 2);

    // R9 input held low across release
    curReq = "R9";
    @(negedge clk); #1 divTwoIn = 1'b0;
    doReset(1'b0);
    repeat (4) @(negedge clk);
    chk(count == 4'd0, "R9", count, 0);
    #1 divTwoIn = 1'b1;
    repeat (2) @(negedge clk); #1 divTwoIn = 1'b0;
    repeat (3) @(negedge clk);
    chk(count == 4'd1, "R9", count, 1);
    #1 divTwoIn = 1'b1;

    // R9 fall on the release cycle
    @(negedge clk); #1 rst = 1'b1;
    repeat (3) @(negedge clk);
    #1 rst = 1'b0; divTwoIn = 1'b0;
    repeat (4) @(negedge clk);
    chk(count == 4'd0, "R9", count, 0);
    #1 divTwoIn = 1'b1;
    repeat (2) @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule